// File: doc/BRIEF.md
# Instruction Fetch Region Guard

This block decides, for every instruction fetch, whether the fetch may proceed. It holds four programmable address regions and one default (global) region. Each region has a base page, a size given as a thermometer mask of pages, an access-level field, a guarded flag and a code-format field. The format field ties the region to the processor's current decompression mode. Regions may overlap. Among the enabled regions that contain the fetch address, the one with the lowest index supplies the attributes. When no enabled region contains the address, the global attributes apply.

A fetch is presented with a one-cycle strobe, together with the upper 20 address bits (bits 31..12, one 4 KB page per step), the privilege level and the decompression mode. One cycle later the block reports either a grant or an abort. An abort carries a one-hot cause. Software programs the regions through a small register port that answers only to supervisor accesses. After reset every region is disabled and the global region lets both privilege levels fetch everywhere.

The verdict comes from a three-state machine. The states are IDLE (no result), GRANT and DENY. On a cycle with the strobe high, each state moves to GRANT if the checks pass and to DENY otherwise. On a cycle with the strobe low, each state moves to IDLE.

Top module: `fetch_guard`

## Requirements
- R1: After reset all four regions are disabled and the global region allows fetches by both user and supervisor. Reading the global register then returns 0x0002_0000.
- R2: A region contains a fetch page when page and base agree in every bit where the size mask is 0. A size mask of k ones from bit 0 upward gives a region of 4 KB·2^k.
- R3: When several enabled regions contain the page, the lowest-indexed region supplies the attributes.
- R4: When no enabled region contains the page, the global access-level and guarded fields decide. The global region carries no format restriction.
- R5: A region whose enable bit (global register bit i) is 0 never contains any page.
- R6: The 2-bit access-level field grants nobody when 00, the supervisor only when 01, and both levels when its upper bit is 1.
- R7: A fetch from a guarded region is aborted.
- R8: The 2-bit format field places no restriction when bit 0 is 0. The value 01 allows fetches only with decompression off, and 11 allows them only with decompression on.
- R9: An abort sets exactly one cause bit: bit 0 for access level, bit 1 for guarded, bit 2 for format. Access level ranks above guarded, and guarded ranks above format. A grant shows cause 000.
- R10: A fetch strobed in one cycle shows its grant or abort in the next cycle only. Back-to-back fetches each give one result. With no strobe both outputs stay low.
- R11: Register writes and reads with reg_sup low have no effect; such a read returns 0. Either kind of access raises reg_fault for one cycle, in the cycle after the access.
- R12: Registers 0..3 are region bases, with the page in data bits 31..12. Registers 4..7 are region attributes: mask in bits 19..0, access level in 21..20, guarded in 22, format in 24..23. Register 8 is global: enables in bits 3..0, access level in 17..16, guarded in 18. Read data appears the cycle after the read, and unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_vld | input | 1 | Fetch strobe, one cycle per fetch |
| fetch_page | input | 20 | Fetch address bits 31..12 |
| fetch_sup | input | 1 | Fetch issued at supervisor level |
| decomp_on | input | 1 | Processor currently runs compressed code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sup | input | 1 | Register access issued at supervisor level |
| reg_sel | input | 4 | Register index (0..8) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after a read |
| reg_fault | output | 1 | User-level register access was refused |
| fetch_ok | output | 1 | Previous-cycle fetch granted |
| fetch_abort | output | 1 | Previous-cycle fetch aborted |
| fetch_cause | output | 3 | One-hot abort cause |

## Verification
Random region sets are tried with random sizes, overlapping bases, enables and attributes. They are hit by fetches spread over a 16 MB window at both privilege levels and in both decompression modes. Each verdict is compared with a bench model of the lowest-index rule, which exposes wrong priority, wrong mask polarity or a missing global fallback.

Directed cases cover the remaining corners:
- the exact last and first pages at a region edge, which separate off-by-one size decoding;
- a denied-and-guarded region, which pins the cause ranking;
- user-level register writes followed by supervisor readback, which shows that the refused write changed nothing.

// File: rtl/fetch_guard_pkg.sv
package fetch_guard_pkg;
    parameter int unsigned NRGN    = 4;
    parameter int unsigned PAGE_W  = 20;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned SEL_W   = $clog2(2 * NRGN + 1);
    parameter int unsigned CAUSE_W = 3;

    localparam int C_PERM  = 0;
    localparam int C_GUARD = 1;
    localparam int C_MODE  = 2;

    // global register field positions
    localparam int GP_LSB = 16;
    localparam int GG_BIT = 18;

    typedef struct packed {
        logic [1:0]        cmpr;
        logic              guard;
        logic [1:0]        prot;
        logic [PAGE_W-1:0] mask;
    } rgn_attr_t;

    localparam int ATTR_W = $bits(rgn_attr_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } fg_state_t;

    function automatic logic [CAUSE_W-1:0] judge(
        input logic [1:0] prot,
        input logic       guard,
        input logic [1:0] cmpr,
        input logic       sup,
        input logic       dec
    );
        logic [CAUSE_W-1:0] c;
        c = '0;
        if (!(prot[1] | (prot[0] & sup)))
            c[C_PERM] = 1'b1;
        else if (guard)
            c[C_GUARD] = 1'b1;
        else if (cmpr[0] && (cmpr[1] != dec))
            c[C_MODE] = 1'b1;
        return c;
    endfunction
endpackage

// File: rtl/fetch_guard_regs.sv
module fetch_guard_regs
    import fetch_guard_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic                         reg_sup,
    input  logic [SEL_W-1:0]             reg_sel,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic                         reg_fault,
    output logic [NRGN-1:0][PAGE_W-1:0]  base,
    output rgn_attr_t [NRGN-1:0]         attr,
    output logic [NRGN-1:0]              glob_en,
    output logic [1:0]                   glob_prot,
    output logic                         glob_guard
);
    localparam int GLOB_SEL = 2 * NRGN;

    logic              wr_ok;
    logic              rd_ok;
    logic [DATA_W-1:0] rd_val;

    assign wr_ok = reg_wr & reg_sup;
    assign rd_ok = reg_rd & reg_sup;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base       <= '0;
            attr       <= '0;
            glob_en    <= '0;
            glob_prot  <= 2'b10;
            glob_guard <= 1'b0;
        end else if (wr_ok) begin
            for (int i = 0; i < NRGN; i++) begin
                if (reg_sel == SEL_W'(i))
                    base[i] <= reg_wdata[DATA_W-1 -: PAGE_W];
                if (reg_sel == SEL_W'(NRGN + i))
                    attr[i] <= rgn_attr_t'(reg_wdata[ATTR_W-1:0]);
            end
            if (reg_sel == SEL_W'(GLOB_SEL)) begin
                glob_en    <= reg_wdata[NRGN-1:0];
                glob_prot  <= reg_wdata[GP_LSB+1:GP_LSB];
                glob_guard <= reg_wdata[GG_BIT];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NRGN; i++) begin
            if (reg_sel == SEL_W'(i))
                rd_val = {base[i], {(DATA_W-PAGE_W){1'b0}}};
            if (reg_sel == SEL_W'(NRGN + i))
                rd_val = {{(DATA_W-ATTR_W){1'b0}}, attr[i]};
        end
        if (reg_sel == SEL_W'(GLOB_SEL)) begin
            rd_val[NRGN-1:0]      = glob_en;
            rd_val[GP_LSB+1:GP_LSB] = glob_prot;
            rd_val[GG_BIT]        = glob_guard;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            reg_fault <= 1'b0;
        end else begin
            if (reg_rd)
                reg_rdata <= rd_ok ? rd_val : '0;
            reg_fault <= (reg_wr | reg_rd) & ~reg_sup;
        end
    end
endmodule

// File: rtl/fetch_guard_rgn.sv
module fetch_guard_rgn
    import fetch_guard_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] base,
    input  logic [PAGE_W-1:0] mask,
    input  logic              en,
    output logic              hit
);
    assign hit = en && (((page ^ base) & ~mask) == '0);
endmodule

// File: rtl/fetch_guard_pick.sv
module fetch_guard_pick
    import fetch_guard_pkg::*;
(
    input  logic [NRGN-1:0]      hit,
    input  rgn_attr_t [NRGN-1:0] attr,
    input  logic [1:0]           glob_prot,
    input  logic                 glob_guard,
    input  logic                 fetch_sup,
    input  logic                 decomp_on,
    output logic [CAUSE_W-1:0]   cause
);
    logic [1:0] eff_prot;
    logic       eff_guard;
    logic [1:0] eff_cmpr;

    always_comb begin
        eff_prot  = glob_prot;
        eff_guard = glob_guard;
        eff_cmpr  = 2'b00;
        // scan downward so the lowest index is applied last and wins
        for (int i = NRGN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                eff_prot  = attr[i].prot;
                eff_guard = attr[i].guard;
                eff_cmpr  = attr[i].cmpr;
            end
        end
        cause = judge(eff_prot, eff_guard, eff_cmpr, fetch_sup, decomp_on);
    end
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard
    import fetch_guard_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_vld,
    input  logic [PAGE_W-1:0]   fetch_page,
    input  logic                fetch_sup,
    input  logic                decomp_on,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic                reg_sup,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_fault,
    output logic                fetch_ok,
    output logic                fetch_abort,
    output logic [CAUSE_W-1:0]  fetch_cause
);
    logic [NRGN-1:0][PAGE_W-1:0] base;
    rgn_attr_t [NRGN-1:0]        attr;
    logic [NRGN-1:0]             glob_en;
    logic [1:0]                  glob_prot;
    logic                        glob_guard;
    logic [NRGN-1:0]             hit;
    logic [CAUSE_W-1:0]          cause_d;
    logic [CAUSE_W-1:0]          cause_q;
    fg_state_t                   state_q;
    fg_state_t                   state_d;

    fetch_guard_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_sup    (reg_sup),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_fault  (reg_fault),
        .base       (base),
        .attr       (attr),
        .glob_en    (glob_en),
        .glob_prot  (glob_prot),
        .glob_guard (glob_guard)
    );

    for (genvar g = 0; g < NRGN; g++) begin : g_rgn
        fetch_guard_rgn u_rgn (
            .page (fetch_page),
            .base (base[g]),
            .mask (attr[g].mask),
            .en   (glob_en[g]),
            .hit  (hit[g])
        );
    end

    fetch_guard_pick u_pick (
        .hit        (hit),
        .attr       (attr),
        .glob_prot  (glob_prot),
        .glob_guard (glob_guard),
        .fetch_sup  (fetch_sup),
        .decomp_on  (decomp_on),
        .cause      (cause_d)
    );

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (fetch_vld)
                    state_d = (cause_d == '0) ? ST_GRANT : ST_DENY;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= fetch_vld ? cause_d : '0;
        end
    end

    // outputs
    always_comb begin
        fetch_ok    = 1'b0;
        fetch_abort = 1'b0;
        fetch_cause = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: fetch_ok = 1'b1;
            ST_DENY: begin
                fetch_abort = 1'b1;
                fetch_cause = cause_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fetch_guard_chk.sv
module fetch_guard_chk
    import fetch_guard_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_vld,
    input logic               fetch_ok,
    input logic               fetch_abort,
    input logic [CAUSE_W-1:0] fetch_cause,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic               reg_sup,
    input logic               reg_fault
);
    // R10
    verdict_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |=> (fetch_ok ^ fetch_abort));

    // R10
    quiet_without_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> (!fetch_ok && !fetch_abort && fetch_cause == '0));

    // R9
    single_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_abort |-> ($countones(fetch_cause) == 1));

    // R9
    clean_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ok |-> (fetch_cause == '0));

    // R11
    user_reg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && !reg_sup) |=> reg_fault);

    // R11
    no_spurious_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((reg_wr || reg_rd) && !reg_sup) |=> !reg_fault);
endmodule

bind fetch_guard fetch_guard_chk u_chk (.*);

// File: tb/sim_fetch_guard.sv
`timescale 1ns/1ps
module sim_fetch_guard;
    import fetch_guard_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                fetch_vld = 1'b0;
    logic [PAGE_W-1:0]   fetch_page = '0;
    logic                fetch_sup = 1'b0;
    logic                decomp_on = 1'b0;
    logic                reg_wr = 1'b0;
    logic                reg_rd = 1'b0;
    logic                reg_sup = 1'b0;
    logic [SEL_W-1:0]    reg_sel = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic [DATA_W-1:0]   reg_rdata;
    logic                reg_fault;
    logic                fetch_ok;
    logic                fetch_abort;
    logic [CAUSE_W-1:0]  fetch_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the programmed state
    logic [PAGE_W-1:0] m_base [NRGN];
    logic [24:0]       m_attr [NRGN];
    logic [NRGN-1:0]   m_en;
    logic [1:0]        m_gprot;
    logic              m_gguard;

    always #5 clk = ~clk;

    fetch_guard u0 (.*);

    function automatic logic [2:0] exp_cause(logic [PAGE_W-1:0] pg, logic sup, logic dec);
        logic [1:0] prot;
        logic guard;
        logic [1:0] cmpr;
        prot = m_gprot; guard = m_gguard; cmpr = 2'b00;
        for (int i = NRGN - 1; i >= 0; i--) begin
            if (m_en[i] && (((pg ^ m_base[i]) & ~m_attr[i][19:0]) == 0)) begin
                prot = m_attr[i][21:20]; guard = m_attr[i][22]; cmpr = m_attr[i][24:23];
            end
        end
        if (!(prot[1] || (prot[0] && sup))) return 3'b001;
        if (guard) return 3'b010;
        if (cmpr[0] && (cmpr[1] != dec)) return 3'b100;
        return 3'b000;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input int sel, input logic [31:0] d, input logic sup, input string tag);
        reg_wr = 1'b1; reg_sup = sup; reg_sel = SEL_W'(sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sup = 1'b0;
        chk({31'd0, reg_fault}, {31'd0, ~sup}, tag);
        if (sup) begin
            if (sel < NRGN) m_base[sel] = d[31:12];
            else if (sel < 2 * NRGN) m_attr[sel-NRGN] = d[24:0];
            else if (sel == 2 * NRGN) begin
                m_en = d[3:0]; m_gprot = d[17:16]; m_gguard = d[18];
            end
        end
    endtask

    task automatic rd(input int sel, input logic sup, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_sup = sup; reg_sel = SEL_W'(sel);
        @(negedge clk);
        reg_rd = 1'b0; reg_sup = 1'b0;
        chk(reg_rdata, exp, tag);
        chk({31'd0, reg_fault}, {31'd0, ~sup}, tag);
    endtask

    task automatic fetch(input logic [PAGE_W-1:0] pg, input logic sup, input logic dec, input string tag);
        logic [2:0] e;
        fetch_vld = 1'b1; fetch_page = pg; fetch_sup = sup; decomp_on = dec;
        @(negedge clk);
        fetch_vld = 1'b0;
        e = exp_cause(pg, sup, dec);
        chk({27'd0, fetch_ok, fetch_abort, fetch_cause},
            {27'd0, (e == 3'b000), (e != 3'b000), e}, tag);
    endtask

    task automatic idle_chk(input string tag);
        @(negedge clk);
        chk({27'd0, fetch_ok, fetch_abort, fetch_cause}, 32'd0, tag);
    endtask

    function automatic logic [31:0] attr_word(int k, logic [1:0] prot, logic g, logic [1:0] cm);
        logic [19:0] msk;
        msk = 20'((64'd1 << k) - 1);
        return {7'd0, cm, g, prot, msk};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        for (int i = 0; i < NRGN; i++) begin m_base[i] = '0; m_attr[i] = '0; end
        m_en = '0; m_gprot = 2'b10; m_gguard = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({27'd0, fetch_ok, fetch_abort, fetch_cause}, 32'd0, "R1 idle outputs after reset");
        chk(reg_rdata, 32'd0, "R1 rdata after reset");
        rd(8, 1'b1, 32'h0002_0000, "R1 global reset value");
        fetch(20'h12345, 1'b0, 1'b0, "R1 user fetch open after reset");
        fetch(20'hFFFFF, 1'b1, 1'b1, "R1 supervisor fetch open after reset");

        // R12 field layout and readback
        wr(0, 32'h1234_5FFF, 1'b1, "R12 base write");
        rd(0, 1'b1, 32'h1234_5000, "R12 base readback");
        wr(4, 32'hFFFF_FFFF, 1'b1, "R12 attr write");
        rd(4, 1'b1, 32'h01FF_FFFF, "R12 attr readback");
        wr(8, 32'hFFFF_FFFF, 1'b1, "R12 global write");
        rd(8, 1'b1, 32'h0007_000F, "R12 global readback");
        wr(8, 32'h0002_0000, 1'b1, "R12 global restore");

        // R11 user accesses ignored
        wr(8, 32'h0000_000F, 1'b0, "R11 user write faults");
        rd(8, 1'b1, 32'h0002_0000, "R11 user write left global unchanged");
        rd(0, 1'b0, 32'h0000_0000, "R11 user read returns zero");

        // R2 region edges: region0 at page 0x00100, 16 pages (64 KB), no access
        wr(0, 32'h0010_0000, 1'b1, "R2 base0");
        wr(4, attr_word(4, 2'b00, 1'b0, 2'b00), 1'b1, "R2 attr0");
        wr(8, 32'h0002_0001, 1'b1, "R2 enable r0");
        fetch(20'h0010F, 1'b1, 1'b0, "R2 last page inside denied");
        chk({29'd0, fetch_cause}, 32'd1, "R2 last page cause perm");
        fetch(20'h00110, 1'b1, 1'b0, "R2 first page past end allowed");
        fetch(20'h000FF, 1'b0, 1'b0, "R2 page below base allowed");

        // R3 overlap: region1 bigger, open; region0 wins inside its range
        wr(1, 32'h0000_0000, 1'b1, "R3 base1");
        wr(5, attr_word(10, 2'b10, 1'b0, 2'b00), 1'b1, "R3 attr1");
        wr(8, 32'h0000_0003, 1'b1, "R3 enable r0 r1, global none");
        fetch(20'h00105, 1'b1, 1'b0, "R3 lowest index wins");
        fetch(20'h00200, 1'b0, 1'b0, "R3 region1 grants outside region0");
        // R4 no match -> global no access
        fetch(20'h00800, 1'b1, 1'b0, "R4 global no access denies");
        // R5 disable region0 -> region1 governs
        wr(8, 32'h0000_0002, 1'b1, "R5 disable r0");
        fetch(20'h00105, 1'b0, 1'b0, "R5 disabled region ignored");

        // R6 supervisor-only
        wr(6, attr_word(0, 2'b01, 1'b0, 2'b00), 1'b1, "R6 attr2");
        wr(2, 32'h0050_0000, 1'b1, "R6 base2");
        wr(8, 32'h0002_0004, 1'b1, "R6 enable r2");
        fetch(20'h00500, 1'b0, 1'b0, "R6 user denied");
        fetch(20'h00500, 1'b1, 1'b0, "R6 supervisor allowed");
        wr(6, attr_word(0, 2'b11, 1'b0, 2'b00), 1'b1, "R6 attr2 both");
        fetch(20'h00500, 1'b0, 1'b0, "R6 user allowed 11");

        // R7 guarded
        wr(6, attr_word(0, 2'b10, 1'b1, 2'b00), 1'b1, "R7 attr2 guarded");
        fetch(20'h00500, 1'b1, 1'b0, "R7 guarded abort");
        // R9 ranking: no access and guarded -> perm cause
        wr(6, attr_word(0, 2'b00, 1'b1, 2'b11), 1'b1, "R9 attr2 all bad");
        fetch(20'h00500, 1'b1, 1'b0, "R9 perm outranks guard");
        wr(6, attr_word(0, 2'b10, 1'b1, 2'b11), 1'b1, "R9 attr2 guard+mode");
        fetch(20'h00500, 1'b1, 1'b0, "R9 guard outranks mode");

        // R8 format field
        wr(6, attr_word(0, 2'b10, 1'b0, 2'b01), 1'b1, "R8 attr2 plain only");
        fetch(20'h00500, 1'b1, 1'b1, "R8 plain region decomp on aborts");
        fetch(20'h00500, 1'b1, 1'b0, "R8 plain region decomp off ok");
        wr(6, attr_word(0, 2'b10, 1'b0, 2'b11), 1'b1, "R8 attr2 compressed only");
        fetch(20'h00500, 1'b1, 1'b0, "R8 compressed region decomp off aborts");
        fetch(20'h00500, 1'b1, 1'b1, "R8 compressed region decomp on ok");
        wr(6, attr_word(0, 2'b10, 1'b0, 2'b10), 1'b1, "R8 attr2 x0");
        fetch(20'h00500, 1'b1, 1'b1, "R8 unrestricted on");
        fetch(20'h00500, 1'b1, 1'b0, "R8 unrestricted off");

        // R10 back-to-back then idle
        fetch(20'h00500, 1'b0, 1'b0, "R10 back-to-back first");
        fetch(20'h00900, 1'b0, 1'b0, "R10 back-to-back second");
        idle_chk("R10 no strobe no result");
        idle_chk("R10 stays idle");

        // R2 R3 R4 R5 R6 R7 R8 random configurations
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < NRGN; i++) begin
                int k;
                logic [19:0] msk;
                k = $urandom_range(0, 10);
                msk = 20'((64'd1 << k) - 1);
                wr(i, {(20'($urandom_range(0, 4095)) & ~msk), 12'h0}, 1'b1, "R12 random base");
                wr(NRGN + i, attr_word(k, 2'($urandom_range(0, 3)),
                   ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3))), 1'b1, "R12 random attr");
            end
            wr(8, {13'd0, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 12'd0,
                   4'($urandom_range(0, 15))}, 1'b1, "R4 random global");
            for (int f = 0; f < 40; f++) begin
                fetch(20'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), "R3 random fetch verdict");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule